// File: doc/BRIEF.md
# SMBus Target Address Dispatcher

This block listens to a synchronized SMBus/I2C clock and data pair. When it sees a start condition, it shifts in the first byte of the transfer, MSB first. That byte holds a 7-bit address in bits 7:1 and the read/write flag in bit 0. The block compares the byte against five candidate addresses in a fixed priority order:

1. the host-notify address 10h;
2. the ARP default address C2h;
3. a programmable general-purpose buffer address;
4. and 5. two programmable ordinary target addresses.

Each candidate has its own enable, and a global target enable gates all of them.

When a byte is accepted, the block pulls SDA low for the ninth SCL clock. At the same time it emits a single-cycle strobe. The strobe carries a 2-bit category code, which tells a downstream protocol engine which engine should take the transfer. It also carries the received read/write bit. On a refusal, SDA stays released and the block goes back to waiting for the next start.

A stop or a repeated start at any point abandons the byte in progress. An optional setting drops bit 0 from every comparison.

Top module: `smb_addr_dispatch`

## Requirements
- R1: The block is idle until a start condition is seen and eight bits are sampled on rising SCL edges, MSB first. Bytes clocked without a preceding start, including data bytes after an accepted address, are never acknowledged and never strobed.
- R2: With `tgtEnable` low, every address byte is refused and no strobe is emitted.
- R3: A byte equal to 10h selects category code 0. It is acknowledged only if `hostEn` is high.
- R4: A byte equal to C2h selects category code 1. It is acknowledged only if `arpEn` is high.
- R5: A byte equal to `bufAddr` selects category code 2. It is acknowledged only if `bufEn` is high.
- R6: A byte equal to `tgtAddr0` with `tgtAddr0En` high, or equal to `tgtAddr1` with `tgtAddr1En` high, selects category code 3 and is acknowledged.
- R7: Matching follows the order 10h, C2h, `bufAddr`, then the two target addresses. The first candidate that matches decides the outcome even when its enable is low. A byte matching no candidate is refused.
- R8: With `ignoreRw` low, all eight bits are compared. With it high, only bits 7:1 are compared.
- R9: On acceptance, `sdaPullDown` rises one clock after the SCL falling edge that ends the eighth bit. It falls one clock after the next SCL falling edge, which ends the ninth bit. On refusal it stays low, and later bytes get no acknowledge until a new start.
- R10: A stop (SDA rising while SCL is high) returns the block to idle. A repeated start (SDA falling while SCL is high) restarts address reception from bit 7. Both abandon any partial byte.
- R11: `catValid` is high for exactly one clock, in the first clock in which `sdaPullDown` is high. In that clock `catCode` holds the category and `catRead` holds bit 0 of the received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronized SCL level |
| sdaIn | input | 1 | Synchronized SDA level |
| tgtEnable | input | 1 | Global target-mode enable |
| ignoreRw | input | 1 | Exclude bit 0 from all comparisons |
| hostEn | input | 1 | Enable for the 10h host-notify address |
| arpEn | input | 1 | Enable for the C2h ARP address |
| bufEn | input | 1 | Enable for the buffer address |
| bufAddr | input | 8 | Programmable buffer address byte |
| tgtAddr0En | input | 1 | Enable for target address 0 |
| tgtAddr0 | input | 8 | Programmable target address 0 |
| tgtAddr1En | input | 1 | Enable for target address 1 |
| tgtAddr1 | input | 8 | Programmable target address 1 |
| sdaPullDown | output | 1 | Drive SDA low (acknowledge) |
| catValid | output | 1 | One-cycle acceptance strobe |
| catCode | output | 2 | Category: 0 host notify, 1 ARP, 2 buffer, 3 target |
| catRead | output | 1 | Received read/write bit |

## Verification
Faults in the bit counter or the shift register show up at the end of the first affected byte. Either the pull-down appears after the wrong number of SCL edges, or the wrong category code is strobed. Because the bench compares against its model every clock, such a fault is caught within one clock of the ninth bit. A state machine stuck outside idle after a stop or refusal shows at the next unsolicited byte, as an acknowledge that should not happen. A wrong priority decode shows as a wrong code or a missing strobe on the overlapping-address trials.

// File: rtl/smbad_pkg.sv
package smbad_pkg;

  localparam int BYTE_W   = 8;
  localparam int NUM_CAND = 5;

  localparam int IDX_HOST = 0;
  localparam int IDX_ARP  = 1;
  localparam int IDX_BUF  = 2;
  localparam int IDX_T0   = 3;
  localparam int IDX_T1   = 4;

  localparam logic [BYTE_W-1:0] HOST_NOTIFY_BYTE = 8'h10;
  localparam logic [BYTE_W-1:0] ARP_DEFAULT_BYTE = 8'hC2;

  typedef enum logic [1:0] {
    CAT_HOST = 2'd0,
    CAT_ARP  = 2'd1,
    CAT_BUF  = 2'd2,
    CAT_TGT  = 2'd3
  } cat_e;

  typedef struct packed {
    logic clearShift;
    logic shiftEn;
  } ctrl_s;

  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
  } busEv_s;

endpackage

// File: rtl/smbad_match.sv
module smbad_match
  import smbad_pkg::*;
#(
  parameter int W = BYTE_W,
  parameter int N = NUM_CAND
) (
  input  logic [W-1:0]        rxByte,
  input  logic                ignoreRw,
  input  logic                tgtEnable,
  input  logic [N-1:0][W-1:0] candAddr,
  input  logic [N-1:0]        candEn,
  output logic                decAck,
  output cat_e                decCat
);

  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = ignoreRw ? (rxByte[W-1:1] == candAddr[i][W-1:1])
                             : (rxByte == candAddr[i]);
  end

  logic rawAck;

  always_comb begin
    rawAck = 1'b0;
    decCat = CAT_TGT;
    if (hit[IDX_HOST]) begin
      decCat = CAT_HOST;
      rawAck = candEn[IDX_HOST];
    end else if (hit[IDX_ARP]) begin
      decCat = CAT_ARP;
      rawAck = candEn[IDX_ARP];
    end else if (hit[IDX_BUF]) begin
      decCat = CAT_BUF;
      rawAck = candEn[IDX_BUF];
    end else if (hit[IDX_T0] || hit[IDX_T1]) begin
      decCat = CAT_TGT;
      rawAck = (hit[IDX_T0] && candEn[IDX_T0]) || (hit[IDX_T1] && candEn[IDX_T1]);
    end
  end

  assign decAck = rawAck && tgtEnable;

endmodule

// File: rtl/smbad_datapath.sv
module smbad_datapath
  import smbad_pkg::*;
#(
  parameter int W = BYTE_W,
  parameter int N = NUM_CAND
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  ctrl_s               ctrl,
  input  logic                ignoreRw,
  input  logic                tgtEnable,
  input  logic [N-1:0][W-1:0] candAddr,
  input  logic [N-1:0]        candEn,
  output busEv_s              ev,
  output logic                lastBit,
  output logic                rwBit,
  output logic                decAck,
  output cat_e                decCat
);

  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(W - 1);

  logic             sclQ, sdaQ;
  logic [CNT_W-1:0] bitCnt;
  logic [W-1:0]     rxByte;

  always_comb begin
    ev.start   = sclIn && sclQ && sdaQ && !sdaIn;
    ev.stop    = sclIn && sclQ && !sdaQ && sdaIn;
    ev.sclRise = sclIn && !sclQ;
    ev.sclFall = !sclIn && sclQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ   <= 1'b1;
      sdaQ   <= 1'b1;
      bitCnt <= '0;
      rxByte <= '0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (ctrl.clearShift) begin
        bitCnt <= '0;
      end else if (ctrl.shiftEn) begin
        rxByte <= {rxByte[W-2:0], sdaIn};
        bitCnt <= (bitCnt == LAST_IDX) ? '0 : bitCnt + 1'b1;
      end
    end
  end

  assign lastBit = (bitCnt == LAST_IDX);
  assign rwBit   = rxByte[0];

  smbad_match #(.W(W), .N(N)) u_match (
    .rxByte    (rxByte),
    .ignoreRw  (ignoreRw),
    .tgtEnable (tgtEnable),
    .candAddr  (candAddr),
    .candEn    (candEn),
    .decAck    (decAck),
    .decCat    (decCat)
  );

  AST_START_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clearShift |=> (bitCnt == '0)); // R10

  AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftEn |=> (rxByte[0] == $past(sdaIn))); // R1

endmodule

// File: rtl/smbad_control.sv
module smbad_control
  import smbad_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclIn,
  input  logic   tgtEnable,
  input  busEv_s ev,
  input  logic   lastBit,
  input  logic   rwBit,
  input  logic   decAck,
  input  cat_e   decCat,
  output ctrl_s  ctrl,
  output logic   sdaPullDown,
  output logic   catValid,
  output cat_e   catCode,
  output logic   catRead
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DECIDE,
    ST_ACKHOLD,
    ST_BUSY
  } state_e;

  state_e state, nextState;
  logic   fire;

  always_comb begin
    nextState       = state;
    fire            = 1'b0;
    ctrl.clearShift = 1'b0;
    ctrl.shiftEn    = 1'b0;
    if (ev.start) begin
      nextState       = ST_ADDR;
      ctrl.clearShift = 1'b1;
    end else if (ev.stop) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (ev.sclRise) begin
            ctrl.shiftEn = 1'b1;
            if (lastBit) nextState = ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          if (ev.sclFall) begin
            if (decAck) begin
              nextState = ST_ACKHOLD;
              fire      = 1'b1;
            end else begin
              nextState = ST_IDLE;
            end
          end
        end
        ST_ACKHOLD: begin
          if (ev.sclFall) nextState = ST_BUSY;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      sdaPullDown <= 1'b0;
      catValid    <= 1'b0;
      catCode     <= CAT_HOST;
      catRead     <= 1'b0;
    end else begin
      state       <= nextState;
      sdaPullDown <= (nextState == ST_ACKHOLD);
      catValid    <= fire;
      if (fire) begin
        catCode <= decCat;
        catRead <= rwBit;
      end
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    catValid |=> !catValid); // R11

  AST_STROBE_AT_PULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullDown) |-> catValid); // R11

  AST_ACK_NEEDS_TGT: assert property (@(posedge clk) disable iff (!rstN)
    catValid |-> $past(tgtEnable)); // R2

  AST_PULL_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaPullDown)); // R9

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    ev.stop |=> (!sdaPullDown && !catValid)); // R10

endmodule

// File: rtl/smb_addr_dispatch.sv
module smb_addr_dispatch
  import smbad_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              tgtEnable,
  input  logic              ignoreRw,
  input  logic              hostEn,
  input  logic              arpEn,
  input  logic              bufEn,
  input  logic [BYTE_W-1:0] bufAddr,
  input  logic              tgtAddr0En,
  input  logic [BYTE_W-1:0] tgtAddr0,
  input  logic              tgtAddr1En,
  input  logic [BYTE_W-1:0] tgtAddr1,
  output logic              sdaPullDown,
  output logic              catValid,
  output logic [1:0]        catCode,
  output logic              catRead
);

  logic [NUM_CAND-1:0][BYTE_W-1:0] candAddr;
  logic [NUM_CAND-1:0]             candEn;

  always_comb begin
    candAddr[IDX_HOST] = HOST_NOTIFY_BYTE;
    candAddr[IDX_ARP]  = ARP_DEFAULT_BYTE;
    candAddr[IDX_BUF]  = bufAddr;
    candAddr[IDX_T0]   = tgtAddr0;
    candAddr[IDX_T1]   = tgtAddr1;
    candEn[IDX_HOST]   = hostEn;
    candEn[IDX_ARP]    = arpEn;
    candEn[IDX_BUF]    = bufEn;
    candEn[IDX_T0]     = tgtAddr0En;
    candEn[IDX_T1]     = tgtAddr1En;
  end

  ctrl_s  ctrl;
  busEv_s ev;
  logic   lastBit, rwBit, decAck;
  cat_e   decCat, catCodeE;

  smbad_datapath #(.W(BYTE_W), .N(NUM_CAND)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .ctrl      (ctrl),
    .ignoreRw  (ignoreRw),
    .tgtEnable (tgtEnable),
    .candAddr  (candAddr),
    .candEn    (candEn),
    .ev        (ev),
    .lastBit   (lastBit),
    .rwBit     (rwBit),
    .decAck    (decAck),
    .decCat    (decCat)
  );

  smbad_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclIn),
    .tgtEnable   (tgtEnable),
    .ev          (ev),
    .lastBit     (lastBit),
    .rwBit       (rwBit),
    .decAck      (decAck),
    .decCat      (decCat),
    .ctrl        (ctrl),
    .sdaPullDown (sdaPullDown),
    .catValid    (catValid),
    .catCode     (catCodeE),
    .catRead     (catRead)
  );

  assign catCode = catCodeE;

endmodule

// File: tb/smb_addr_dispatch_bench.sv
module smb_addr_dispatch_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterScl = 1'b1;
  logic masterSda = 1'b1;
  logic tgtEnable, ignoreRw, hostEn, arpEn, bufEn, tgtAddr0En, tgtAddr1En;
  logic [7:0] bufAddr, tgtAddr0, tgtAddr1;
  logic sdaPullDown, catValid, catRead;
  logic [1:0] catCode;
  logic busSda;

  assign busSda = masterSda & ~sdaPullDown;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_addr_dispatch u_smb_addr_dispatch (
    .clk(clk), .rstN(rstN), .sclIn(masterScl), .sdaIn(busSda),
    .tgtEnable(tgtEnable), .ignoreRw(ignoreRw), .hostEn(hostEn), .arpEn(arpEn),
    .bufEn(bufEn), .bufAddr(bufAddr), .tgtAddr0En(tgtAddr0En), .tgtAddr0(tgtAddr0),
    .tgtAddr1En(tgtAddr1En), .tgtAddr1(tgtAddr1),
    .sdaPullDown(sdaPullDown), .catValid(catValid), .catCode(catCode), .catRead(catRead)
  );

  int checks = 0;
  int fails = 0;
  int strobeCnt = 0;
  int lastCode = 0;
  int lastRead = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: decision per requirements R2-R8
  function automatic int refDecide(input int v, output bit ack);
    int cands[5];
    bit ens[5];
    int hitIdx;
    cands = '{16'h10, 16'hC2, int'(bufAddr), int'(tgtAddr0), int'(tgtAddr1)};
    ens   = '{hostEn, arpEn, bufEn, tgtAddr0En, tgtAddr1En};
    hitIdx = -1;
    ack = 0;
    for (int i = 0; i < 5; i++) begin
      bit same;
      same = ignoreRw ? ((v >> 1) == (cands[i] >> 1)) : (v == cands[i]);
      if (same && hitIdx < 0) hitIdx = i;
      if (same && i >= 3 && ens[i]) ack = (hitIdx >= 3);
    end
    if (hitIdx >= 0 && hitIdx < 3) ack = ens[hitIdx];
    if (!tgtEnable) ack = 0;
    if (hitIdx < 0) return 3;
    return (hitIdx >= 3) ? 3 : hitIdx;
  endfunction

  // Cycle model
  int  mSt = 0;
  bit  pScl = 1, pSda = 1;
  bit  expPull = 0, expValid = 0;
  int  expCode = 0, expRead = 0;
  bit  bitsQ[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; pScl = 1; pSda = 1; expPull = 0; expValid = 0; bitsQ.delete();
    end else begin
      bit s, d, st, sp, rise, fall;
      s = masterScl; d = busSda;
      st = s && pScl && pSda && !d;
      sp = s && pScl && !pSda && d;
      rise = s && !pScl;
      fall = !s && pScl;
      expValid = 0;
      if (st) begin
        mSt = 1; bitsQ.delete(); expPull = 0;
      end else if (sp) begin
        mSt = 0; expPull = 0;
      end else begin
        case (mSt)
          1: if (rise) begin
               bitsQ.push_back(d);
               if (bitsQ.size() == 8) mSt = 2;
             end
          2: if (fall) begin
               int v; bit a; int c;
               v = 0;
               foreach (bitsQ[k]) v = (v << 1) | int'(bitsQ[k]);
               c = refDecide(v, a);
               if (a) begin
                 expPull = 1; expValid = 1; expCode = c; expRead = v & 1; mSt = 3;
               end else mSt = 0;
             end
          3: if (fall) begin expPull = 0; mSt = 4; end
          default: ;
        endcase
      end
      pScl = s; pSda = d;
    end
  end

  always @(negedge clk) begin
    if (!rstN) begin
      check(sdaPullDown == 0 && catValid == 0, "R1 reset", int'(sdaPullDown) + int'(catValid), 0);
    end else begin
      check(sdaPullDown == expPull, "R9 pull", sdaPullDown, expPull);
      check(catValid == expValid, "R11 strobe", catValid, expValid);
      if (catValid && expValid) begin
        check(int'(catCode) == expCode, "R11 code", catCode, expCode);
        check(int'(catRead) == expRead, "R11 rw", catRead, expRead);
      end
      if (catValid) begin
        strobeCnt++; lastCode = catCode; lastRead = catRead;
      end
    end
  end

  task automatic halfWait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic busStart();
    masterSda = 1; halfWait();
    masterScl = 1; halfWait();
    masterSda = 0; halfWait();
    masterScl = 0; halfWait();
  endtask

  task automatic busStop();
    masterScl = 0; masterSda = 0; halfWait();
    masterScl = 1; halfWait();
    masterSda = 1; halfWait();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      masterSda = b[7-i]; halfWait();
      masterScl = 1; halfWait();
      masterScl = 0;
    end
  endtask

  task automatic ninth(output bit acked);
    masterSda = 1; halfWait();
    masterScl = 1; repeat (2) @(negedge clk);
    acked = !busSda;
    repeat (2) @(negedge clk);
    masterScl = 0; halfWait();
  endtask

  task automatic trial(input logic [7:0] b, input bit expAck, input int expC, input string req);
    int sc0; bit a;
    sc0 = strobeCnt;
    busStart();
    sendBits(b, 8);
    ninth(a);
    busStop();
    check(a == expAck, req, a, expAck);
    check((strobeCnt - sc0) == int'(expAck), req, strobeCnt - sc0, expAck);
    if (expAck) begin
      check(lastCode == expC, req, lastCode, expC);
      check(lastRead == int'(b[0]), req, lastRead, b[0]);
    end
  endtask

  initial begin
    bit a; int sc0;
    tgtEnable = 1; ignoreRw = 0; hostEn = 1; arpEn = 1; bufEn = 1;
    tgtAddr0En = 1; tgtAddr1En = 1;
    bufAddr = 8'h5A; tgtAddr0 = 8'h34; tgtAddr1 = 8'h77;
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (3) @(negedge clk);

    trial(8'h10, 1, 0, "R3 host notify");
    trial(8'hC2, 1, 1, "R4 arp");
    trial(8'h5A, 1, 2, "R5 buffer");
    trial(8'h34, 1, 3, "R6 target0");
    trial(8'h77, 1, 3, "R6 target1");
    trial(8'h35, 0, 0, "R8 rw compared");
    trial(8'h99, 0, 0, "R7 no match");
    ignoreRw = 1;
    trial(8'h35, 1, 3, "R8 rw ignored");
    trial(8'h11, 1, 0, "R8 rw ignored host");
    ignoreRw = 0;
    hostEn = 0;
    trial(8'h10, 0, 0, "R3 host disabled");
    bufAddr = 8'h10;
    trial(8'h10, 0, 0, "R7 priority over buffer");
    bufAddr = 8'h5A; hostEn = 1;
    arpEn = 0;
    trial(8'hC2, 0, 0, "R4 arp disabled");
    arpEn = 1; bufEn = 0;
    trial(8'h5A, 0, 0, "R5 buffer disabled");
    bufEn = 1; tgtAddr0En = 0;
    trial(8'h34, 0, 0, "R6 target0 disabled");
    trial(8'h77, 1, 3, "R6 target1 still on");
    tgtAddr0En = 1; tgtAddr1 = 8'h34; tgtAddr1En = 0;
    trial(8'h34, 1, 3, "R6 either enabled");
    tgtAddr1 = 8'h77; tgtAddr1En = 1;
    tgtEnable = 0;
    trial(8'h10, 0, 0, "R2 target off");
    trial(8'h34, 0, 0, "R2 target off");
    tgtEnable = 1;

    // R9: refusal, then a byte without a new start
    sc0 = strobeCnt;
    busStart(); sendBits(8'h99, 8); ninth(a);
    check(a == 0, "R9 nack", a, 0);
    sendBits(8'h34, 8); ninth(a);
    check(a == 0, "R9 no ack after nack", a, 0);
    busStop();
    check(strobeCnt == sc0, "R9 no strobe", strobeCnt - sc0, 0);

    // R1: data byte after accepted address not acknowledged
    sc0 = strobeCnt;
    busStart(); sendBits(8'h34, 8); ninth(a);
    check(a == 1, "R1 addr ack", a, 1);
    sendBits(8'h10, 8); ninth(a);
    check(a == 0, "R1 data byte ignored", a, 0);
    busStop();
    check((strobeCnt - sc0) == 1, "R1 single strobe", strobeCnt - sc0, 1);

    // R10: stop mid byte, then bits without start
    sc0 = strobeCnt;
    busStart(); sendBits(8'h34, 4); busStop();
    masterScl = 0; halfWait();
    sendBits(8'h34, 8); ninth(a);
    check(a == 0, "R10 stop aborts", a, 0);
    busStop();
    check(strobeCnt == sc0, "R10 no strobe after stop", strobeCnt - sc0, 0);

    // R10: repeated start mid byte
    sc0 = strobeCnt;
    busStart(); sendBits(8'h34, 4);
    busStart(); sendBits(8'h5A, 8); ninth(a);
    busStop();
    check(a == 1, "R10 repeated start ack", a, 1);
    check((strobeCnt - sc0) == 1 && lastCode == 2, "R10 repeated start code", lastCode, 2);

    repeat (5) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule